// File: doc/BRIEF.md
# Clock Divider Bank with Aligned Ratio Update

This block derives several slower clock enables from a single fast PLL output clock. A shared pre-scaler stage (the post-divider) produces a base tick, and each output lane divides that base tick further by its own programmable integer factor. Every output is a one-cycle pulse in the fast clock domain, used downstream as a clock enable.

Software programs the ratios through a small word-addressed register bus. Writes only land in shadow copies, so the running outputs are not disturbed. A GO command starts a transition. Each enabled lane finishes its current period and then waits, held low. When the last lane has finished, all active copies are loaded from the shadows and every counter restarts on one common edge, so the outputs begin in phase. A busy flag reports the transition until that edge.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, the post-divider and every lane read back 0x8000 (enable 1, ratio 0), the status reads 0, and every output pulses on every cycle.
- R2: A lane register sits at word address 4+i. Bit 15 enables lane i and bits [4:0] hold RATIO. An enabled lane pulses once every RATIO+1 base ticks.
- R3: The post-divider register at word address 0 has the same layout. With bit 15 set, the base tick occurs once every RATIO+1 clock cycles. With bit 15 clear, the post-divider is bypassed and the base tick occurs every cycle.
- R4: A register write changes the readback of that register at once. It leaves every output unchanged until the alignment edge of a later GO.
- R5: Writing a 1 to bit 0 at word address 1 while idle sets the busy flag from the next cycle. The flag reads as bit 0 at word address 2.
- R6: During a transition, each enabled lane emits the pulse that ends its current period and then stays low. The alignment edge is the clock edge that ends the cycle in which the last pending lane pulses. On that edge the busy flag clears.
- R7: On the alignment edge the shadow values become active and all counters restart from zero. Lane i therefore next pulses (RATIO_i+1)·(POST+1) cycles later, and all lanes start in phase.
- R8: A GO write while busy is ignored. It neither restarts nor extends the transition in progress.
- R9: A lane whose active enable is 0 never pulses and its counter stays cleared. Re-enabling the lane starts it from zero.
- R10: Reads of the command address and of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational for the addressed register |
| divTick | output | NUM_OUT | One-cycle enable pulse per output lane |
| goBusy | output | 1 | Transition in progress |

## Verification
Read data is combinational and is sampled within the same cycle as the read request. The busy flag rises one clock edge after the GO write. Output pulses are registered-state functions, so the effect of any edge is visible in the following cycle. The bench keeps a behavioural model that takes the same bus inputs at each rising edge and predicts every pulse and the busy flag for the next cycle. It compares these values at every falling edge. Directed checks then count pulses over windows that are whole multiples of the expected period, so the phase of the window does not matter.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int ADDR_POST = 0;
  localparam int ADDR_CMD  = 1;
  localparam int ADDR_STAT = 2;
  localparam int ADDR_DIV0 = 4;
  localparam int EN_BIT    = 15;

  typedef struct packed {
    logic goStart;   // GO accepted this cycle
    logic waiting;   // transition in progress
    logic applyNew;  // alignment edge: load shadows, restart counters
  } ctrlStrobe_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int RATIO_W = 5,
  parameter int ADDR_W  = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busValid,
  input  logic                              busWrite,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic [31:0]                       busWdata,
  output logic [31:0]                       busRdata,
  input  logic                              alignReady,
  output ctrlStrobe_t                       strobe,
  output logic                              shadowPostEn,
  output logic [RATIO_W-1:0]                shadowPostRatio,
  output logic [NUM_OUT-1:0]                shadowEn,
  output logic [NUM_OUT-1:0][RATIO_W-1:0]   shadowRatio,
  output logic                              goBusy
);
  localparam logic [ADDR_W-1:0] A_POST = ADDR_W'(ADDR_POST);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(ADDR_CMD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  logic wrEn, goWrite, busyQ;
  logic postEnQ;
  logic [RATIO_W-1:0] postRatioQ;
  logic unusedWdata;

  assign unusedWdata = ^{busWdata[31:16], busWdata[14:RATIO_W]};
  assign wrEn    = busValid && busWrite;
  assign goWrite = wrEn && (busAddr == A_CMD) && busWdata[0];

  assign strobe.goStart  = goWrite && !busyQ;
  assign strobe.waiting  = busyQ;
  assign strobe.applyNew = busyQ && alignReady;
  assign goBusy          = busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (strobe.goStart) begin
      busyQ <= 1'b1;
    end else if (strobe.applyNew) begin
      busyQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postEnQ    <= 1'b1;
      postRatioQ <= '0;
    end else if (wrEn && busAddr == A_POST) begin
      postEnQ    <= busWdata[EN_BIT];
      postRatioQ <= busWdata[RATIO_W-1:0];
    end
  end
  assign shadowPostEn    = postEnQ;
  assign shadowPostRatio = postRatioQ;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    localparam logic [ADDR_W-1:0] A_LANE = ADDR_W'(ADDR_DIV0 + i);
    logic enQ;
    logic [RATIO_W-1:0] ratioQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ    <= 1'b1;
        ratioQ <= '0;
      end else if (wrEn && busAddr == A_LANE) begin
        enQ    <= busWdata[EN_BIT];
        ratioQ <= busWdata[RATIO_W-1:0];
      end
    end
    assign shadowEn[i]    = enQ;
    assign shadowRatio[i] = ratioQ;
  end

  always_comb begin
    busRdata = '0;
    if (busValid && !busWrite) begin
      if (busAddr == A_POST) begin
        busRdata[EN_BIT]      = postEnQ;
        busRdata[RATIO_W-1:0] = postRatioQ;
      end else if (busAddr == A_STAT) begin
        busRdata[0] = busyQ;
      end
      for (int i = 0; i < NUM_OUT; i++) begin
        if (busAddr == ADDR_W'(ADDR_DIV0 + i)) begin
          busRdata[EN_BIT]      = shadowEn[i];
          busRdata[RATIO_W-1:0] = shadowRatio[i];
        end
      end
    end
  end
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int RATIO_W = 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobe_t                       strobe,
  input  logic                              shadowPostEn,
  input  logic [RATIO_W-1:0]                shadowPostRatio,
  input  logic [NUM_OUT-1:0]                shadowEn,
  input  logic [NUM_OUT-1:0][RATIO_W-1:0]   shadowRatio,
  output logic [NUM_OUT-1:0]                divTick,
  output logic [NUM_OUT-1:0][RATIO_W-1:0]   activeRatio,
  output logic                              alignReady
);
  logic postEnQ;
  logic [RATIO_W-1:0] postRatioQ, postCntQ;
  logic baseTick;
  logic [NUM_OUT-1:0] parked;

  assign baseTick = !postEnQ || (postCntQ == postRatioQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postEnQ    <= 1'b1;
      postRatioQ <= '0;
      postCntQ   <= '0;
    end else if (strobe.applyNew) begin
      postEnQ    <= shadowPostEn;
      postRatioQ <= shadowPostRatio;
      postCntQ   <= '0;
    end else if (!postEnQ || postCntQ == postRatioQ) begin
      postCntQ   <= '0;
    end else begin
      postCntQ   <= postCntQ + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    logic enQ, parkQ, tick;
    logic [RATIO_W-1:0] ratioQ, cntQ;

    assign tick = enQ && baseTick && (cntQ == ratioQ) && !parkQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ    <= 1'b1;
        ratioQ <= '0;
      end else if (strobe.applyNew) begin
        enQ    <= shadowEn[i];
        ratioQ <= shadowRatio[i];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || strobe.applyNew || !enQ || parkQ) begin
        cntQ <= '0;
      end else if (baseTick) begin
        cntQ <= (cntQ == ratioQ) ? '0 : cntQ + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || strobe.applyNew) begin
        parkQ <= 1'b0;
      end else if (strobe.goStart) begin
        parkQ <= !enQ;
      end else if (strobe.waiting && tick) begin
        parkQ <= 1'b1;
      end
    end

    assign divTick[i]     = tick;
    assign parked[i]      = parkQ;
    assign activeRatio[i] = ratioQ;
  end

  assign alignReady = &(parked | divTick);
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int RATIO_W = 5,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic [NUM_OUT-1:0] divTick,
  output logic               goBusy
);
  ctrlStrobe_t strobe;
  logic alignReady, applyNewW;
  logic shadowPostEn;
  logic [RATIO_W-1:0] shadowPostRatio;
  logic [NUM_OUT-1:0] shadowEn;
  logic [NUM_OUT-1:0][RATIO_W-1:0] shadowRatio, activeRatio;

  assign applyNewW = strobe.applyNew;

  clkdiv_ctrl #(.NUM_OUT(NUM_OUT), .RATIO_W(RATIO_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .alignReady(alignReady), .strobe(strobe),
    .shadowPostEn(shadowPostEn), .shadowPostRatio(shadowPostRatio),
    .shadowEn(shadowEn), .shadowRatio(shadowRatio), .goBusy(goBusy)
  );

  clkdiv_datapath #(.NUM_OUT(NUM_OUT), .RATIO_W(RATIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .shadowPostEn(shadowPostEn), .shadowPostRatio(shadowPostRatio),
    .shadowEn(shadowEn), .shadowRatio(shadowRatio),
    .divTick(divTick), .activeRatio(activeRatio), .alignReady(alignReady)
  );
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int RATIO_W = 5,
  parameter int ADDR_W  = 4
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            busValid,
  input logic                            busWrite,
  input logic [ADDR_W-1:0]               busAddr,
  input logic [31:0]                     busWdata,
  input logic                            goBusy,
  input logic                            applyNew,
  input logic [NUM_OUT-1:0][RATIO_W-1:0] activeRatio
);
  // R5
  go_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == ADDR_W'(ADDR_CMD) && busWdata[0] && !goBusy) |=> goBusy);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goBusy && !applyNew) |=> goBusy);

  // R6
  apply_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    applyNew |-> goBusy);

  // R6
  apply_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    applyNew |=> !goBusy);

  // R4
  active_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !applyNew |=> $stable(activeRatio));
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NUM_OUT(NUM_OUT), .RATIO_W(RATIO_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .goBusy(goBusy),
  .applyNew(applyNewW), .activeRatio(activeRatio)
);

// File: tb/clkdiv_bank_tb.sv
module clkdiv_bank_tb;
  localparam int N  = 4;
  localparam int RW = 5;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [N-1:0] divTick;
  logic goBusy;

  int tests = 0, fails = 0;

  // reference model state
  int sPostEn, sPostR, sEn[N], sR[N];
  int mPostEn, mPostR, mPostC, mEn[N], mR[N], mC[N], mPark[N], mBusy;

  always #5 clk = ~clk;

  clkdiv_bank #(.NUM_OUT(N), .RATIO_W(RW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .divTick(divTick), .goBusy(goBusy)
  );

  function automatic int expTick(int i);
    int base;
    base = (mPostEn == 0 || mPostC == mPostR) ? 1 : 0;
    return (mEn[i] != 0 && base != 0 && mC[i] == mR[i] && mPark[i] == 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      sPostEn = 1; sPostR = 0; mPostEn = 1; mPostR = 0; mPostC = 0; mBusy = 0;
      for (int i = 0; i < N; i++) begin
        sEn[i] = 1; sR[i] = 0; mEn[i] = 1; mR[i] = 0; mC[i] = 0; mPark[i] = 0;
      end
    end else begin
      int t[N];
      int base, align, goS;
      base = (mPostEn == 0 || mPostC == mPostR) ? 1 : 0;
      align = mBusy;
      for (int i = 0; i < N; i++) begin
        t[i] = expTick(i);
        if (mPark[i] == 0 && t[i] == 0) align = 0;
      end
      goS = (busValid && busWrite && busAddr == 1 && busWdata[0] && mBusy == 0) ? 1 : 0;
      for (int i = 0; i < N; i++) begin
        int nc, np;
        if (align != 0 || mEn[i] == 0 || mPark[i] != 0) nc = 0;
        else if (base != 0) nc = (mC[i] == mR[i]) ? 0 : mC[i] + 1;
        else nc = mC[i];
        if (align != 0) np = 0;
        else if (goS != 0) np = (mEn[i] == 0) ? 1 : 0;
        else if (mBusy != 0 && t[i] != 0) np = 1;
        else np = mPark[i];
        mC[i] = nc; mPark[i] = np;
        if (align != 0) begin mEn[i] = sEn[i]; mR[i] = sR[i]; end
      end
      if (align != 0) begin mPostEn = sPostEn; mPostR = sPostR; mPostC = 0; end
      else if (mPostEn == 0 || mPostC == mPostR) mPostC = 0;
      else mPostC = mPostC + 1;
      if (goS != 0) mBusy = 1;
      else if (align != 0) mBusy = 0;
      if (busValid && busWrite) begin
        if (busAddr == 0) begin sPostEn = busWdata[15]; sPostR = int'(busWdata[RW-1:0]); end
        for (int i = 0; i < N; i++)
          if (busAddr == AW'(4 + i)) begin sEn[i] = busWdata[15]; sR[i] = int'(busWdata[RW-1:0]); end
      end
    end
  end

  // per-cycle comparison against the model: R2 R3 R4 R6 R7 R9
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < N; i++) begin
        tests++;
        if (int'(divTick[i]) != expTick(i)) begin
          fails++;
          $display("FAIL R2 R6 R7 lane %0d tick at %0t: got %0d exp %0d", i, $time, divTick[i], expTick(i));
        end
      end
      tests++;
      if (int'(goBusy) != mBusy) begin
        fails++;
        $display("FAIL R5 R6 busy at %0t: got %0d exp %0d", $time, goBusy, mBusy);
      end
    end
  end

  task automatic check(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h exp 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = AW'(a); busWdata = 32'(d);
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = AW'(a);
    #1 check(tag, int'(busRdata), exp);
    @(negedge clk);
    busValid = 0;
  endtask

  task automatic countTicks(int lane, int cycles, int exp, string tag);
    int c = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (divTick[lane]) c++;
    end
    check(tag, c, exp);
  endtask

  task automatic waitIdle();
    int k = 0;
    while (goBusy && k < 500) begin @(negedge clk); k++; end
    check("R6 transition ends", int'(goBusy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(0, 32'h8000, "R1 post reset");
    for (int i = 0; i < N; i++) rd(4 + i, 32'h8000, "R1 lane reset");
    rd(2, 0, "R1 status reset");
    countTicks(1, 8, 8, "R1 tick every cycle");
    // R10
    rd(1, 0, "R10 cmd read");
    rd(3, 0, "R10 unmapped read");
    // R4 shadow writes
    wr(4, 32'h8002); wr(5, 32'h8004); wr(6, 32'h0003); wr(7, 32'h8001); wr(0, 32'h8001);
    rd(4, 32'h8002, "R4 shadow readback");
    rd(6, 32'h0003, "R4 shadow readback disabled");
    countTicks(0, 12, 12, "R4 outputs unchanged before GO");
    // R5 GO
    wr(1, 1);
    check("R5 busy after GO", int'(goBusy), 1);
    waitIdle();
    // R2 R3 R7 R9
    countTicks(0, 60, 10, "R2 lane0 period 6");
    countTicks(1, 60, 6, "R2 lane1 period 10");
    countTicks(2, 60, 0, "R9 disabled lane low");
    countTicks(3, 60, 15, "R7 lane3 period 4");
    // R8 GO while busy
    wr(5, 32'h8007);
    wr(1, 1);
    check("R5 busy second GO", int'(goBusy), 1);
    wr(1, 1);
    check("R8 busy kept", int'(goBusy), 1);
    waitIdle();
    countTicks(1, 64, 4, "R2 lane1 period 16");
    // R3 bypass, R9 re-enable
    wr(0, 32'h0000); wr(6, 32'h8000);
    wr(1, 1);
    waitIdle();
    countTicks(2, 20, 20, "R3 bypass R9 re-enabled");
    countTicks(0, 30, 10, "R3 bypass lane0 period 3");
    rd(2, 0, "R5 status idle");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule